// File: doc/BRIEF.md
# Interrupt Priority Mask CPU Interface

This block is the interrupt interface of a single processor core. It watches a small, fixed set of interrupt sources. Each source has a pending input, a group bit and a security bit, and each has a priority held in the block. From the sources that may be delivered, the block picks the most urgent one and raises either the normal or the fast interrupt line toward the core. Priorities are 8-bit numbers, and a smaller number means more urgent.

Two gates decide whether a source may be delivered. The first is a programmable priority mask, which software raises around critical regions instead of disabling interrupts at the core. The second is the running priority, which is the priority of the interrupt the core is currently serving. The core acknowledges an interrupt to obtain its ID. This pushes the old running priority onto a small stack and adopts the priority of the acknowledged source. An end-of-interrupt pops the stack again. Register writes carry a security attribute, and a non-secure write can only place a value in the less urgent half of the range. A separate wake output tells idle logic that a source is pending above the mask, whatever the core's own masks are.

Top module: `prio_cpu_if`

## Requirements
- R1: After reset the mask reads 0x00, every source priority reads 0xFF, the running priority is 0xFF, irq, fiq and wake are low, and ack_id is 1023.
- R2: A secure write (wr_secure=1) stores wr_data unchanged. wr_sel=0 selects the mask and wr_sel=k selects source k-1. rd_sel uses the same encoding and rd_data returns the stored value.
- R3: A non-secure write stores 128 + (wr_data >> 1), i.e. {1'b1, wr_data[7:1]}, for both the mask and the priorities.
- R4: A source is eligible only when it is pending, not active, its priority is strictly below the mask value, and its priority is strictly below the running priority.
- R5: ack_id shows ID_BASE + index of the eligible source with the numerically smallest priority. Among equal priorities, the lowest index wins.
- R6: With no eligible source, ack_id is 1023, and a pulse on ack changes neither the running priority nor any source state.
- R7: An ack with an eligible source sets the running priority to that source's priority and marks the source active. An active source is not selected again until an eoi carries its ID.
- R8: eoi restores the running priority to its value before the matching ack. eoi with an empty stack leaves it at 0xFF. eoi takes precedence over an ack in the same cycle.
- R9: The selected source drives irq when it is group 1 (src_grp=1) and its src_sec equals cur_secure. Otherwise it drives fiq. At most one of the two is high at a time.
- R10: wake is high while any pending, non-active source has a priority strictly below the mask, even if the running priority blocks it. A source blocked by the mask gives no wake.
- R11: While the running-priority stack holds STACK_DEPTH entries, no source is eligible and ack_id is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pend | input | NUM_SRC | Pending level per source |
| src_grp | input | NUM_SRC | Group per source (0 or 1) |
| src_sec | input | NUM_SRC | Security state a group 1 source belongs to (1 = secure) |
| cur_secure | input | 1 | Current security state of the core |
| wr_en | input | 1 | Register write strobe |
| wr_secure | input | 1 | Write is secure |
| wr_sel | input | SEL_W | 0 = mask, k = priority of source k-1 |
| wr_data | input | 8 | Write value |
| rd_sel | input | SEL_W | Readback select, same encoding |
| rd_data | output | 8 | Readback value (0 for unused selects) |
| ack | input | 1 | Acknowledge strobe |
| ack_id | output | 10 | ID returned by an acknowledge (1023 = none) |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID being completed |
| run_prio | output | 8 | Running priority |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |
| wake | output | 1 | Wake request for an idle core |

## Verification
The bench builds the block with four sources, a two-entry running-priority stack and an ID base of 32, at full 8-bit priority resolution. With four sources it can hit a priority tie, both routing outcomes and a mask boundary using a handful of programmed priorities. The two-entry stack is filled after only two nested acknowledges, which makes the stack-full block, the pop order and the empty-stack end-of-interrupt reachable in a short directed sequence.

// File: rtl/prio_if_pkg.sv
// Shared constants, types and write-value helpers for the priority CPU interface.
// Assumes 8-bit priorities where a smaller value is more urgent.
package prio_if_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] PRIO_IDLE   = 8'hFF;

    typedef logic [PRIO_W-1:0] prio_t;

    // Non-secure writes land in the less urgent half: 128 + (v >> 1)
    function automatic prio_t ns_compress(prio_t v);
        return {1'b1, v[PRIO_W-1:1]};
    endfunction

    // Clear the low bits that an implementation with fewer levels does not hold
    function automatic prio_t keep_levels(prio_t v, int unsigned bits);
        prio_t keep;
        keep = prio_t'(8'hFF << (PRIO_W - bits));
        return v & keep;
    endfunction
endpackage

// File: rtl/prio_regs.sv
// Mask and per-source priority registers with security-dependent write compression.
// Assumes select 0 is the mask and select k is source k-1; unused selects ignore writes and read 0.
module prio_regs
    import prio_if_pkg::*;
#(
    parameter int NUM_SRC   = 4,
    parameter int SEL_W     = 3,
    parameter int PRIO_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_secure,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [PRIO_W-1:0]             wr_data,
    input  logic [SEL_W-1:0]              rd_sel,
    output logic [PRIO_W-1:0]             rd_data,
    output logic [PRIO_W-1:0]             mask_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o
);
    prio_t wr_val;

    // Form the value to store from the write attribute and the implemented levels
    always_comb begin
        wr_val = keep_levels(wr_secure ? wr_data : ns_compress(wr_data), PRIO_BITS);
    end

    // Priority mask register, fully masked after reset
    always_ff @(posedge clk) begin
        if (!rst_n)                           mask_o <= '0;
        else if (wr_en && wr_sel == '0)       mask_o <= wr_val;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        // One priority register per source, least urgent after reset
        always_ff @(posedge clk) begin
            if (!rst_n)                                    prio_o[i] <= PRIO_IDLE;
            else if (wr_en && wr_sel == SEL_W'(i + 1))     prio_o[i] <= wr_val;
        end
    end

    // Readback multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_sel == '0) rd_data = mask_o;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_sel == SEL_W'(i + 1)) rd_data = prio_o[i];
        end
    end
endmodule

// File: rtl/prio_select.sv
// Picks the most urgent eligible source and computes the wake request.
// Assumes ties resolve to the lowest index; a stall input blocks every selection.
module prio_select
    import prio_if_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0]             active,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              mask,
    input  logic [PRIO_W-1:0]              run_prio,
    input  logic                           stall,
    output logic                           hit,
    output logic [IDX_W-1:0]               best_idx,
    output logic [PRIO_W-1:0]              best_prio,
    output logic                           wake
);
    logic [NUM_SRC-1:0] below_mask;

    // Sources that are waiting and pass the programmable mask
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            below_mask[i] = pend[i] && !active[i] && (prio[i] < mask);
        end
    end

    // Linear scan for the smallest priority; strict compare keeps the lowest index on ties
    always_comb begin
        hit       = 1'b0;
        best_idx  = '0;
        best_prio = PRIO_IDLE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (below_mask[i] && (prio[i] < run_prio) && (!hit || prio[i] < best_prio)) begin
                hit       = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio[i];
            end
        end
        if (stall) hit = 1'b0;
    end

    // Wake ignores the running priority and the stall
    always_comb begin
        wake = |below_mask;
    end
endmodule

// File: rtl/prio_run_stack.sv
// Running priority register with a stack of the values it held before each acknowledge.
// Assumes pop has precedence over push; a pop on an empty stack does nothing.
module prio_run_stack
    import prio_if_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [PRIO_W-1:0] run_prio,
    output logic              full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  cnt;
    prio_t             stk [DEPTH];
    prio_t             top;

    // Entry under the current running priority
    always_comb begin
        top = PRIO_IDLE;
        for (int k = 0; k < DEPTH; k++) begin
            if (cnt == CNT_W'(k + 1)) top = stk[k];
        end
    end

    assign full = (cnt == CNT_W'(DEPTH));

    // Push on acknowledge, pop on end-of-interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_prio <= PRIO_IDLE;
            cnt      <= '0;
            for (int k = 0; k < DEPTH; k++) stk[k] <= PRIO_IDLE;
        end else if (pop) begin
            if (cnt != '0) begin
                run_prio <= top;
                cnt      <= cnt - 1'b1;
            end
        end else if (push && !full) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (cnt == CNT_W'(k)) stk[k] <= run_prio;
            end
            run_prio <= push_prio;
            cnt      <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/prio_cpu_if.sv
// Single-core interrupt interface: priority mask, running-priority gate, IRQ/FIQ routing.
// Assumes source i has ID ID_BASE+i, that 1023 stays outside that range, and NUM_SRC >= 2.
module prio_cpu_if
    import prio_if_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int STACK_DEPTH = 2,
    parameter int ID_BASE     = 32,
    parameter int PRIO_BITS   = 8,
    localparam int SEL_W      = $clog2(NUM_SRC + 1),
    localparam int IDX_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_grp,
    input  logic [NUM_SRC-1:0] src_sec,
    input  logic               cur_secure,
    input  logic               wr_en,
    input  logic               wr_secure,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [7:0]         wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [7:0]         rd_data,
    input  logic               ack,
    output logic [9:0]         ack_id,
    input  logic               eoi,
    input  logic [9:0]         eoi_id,
    output logic [7:0]         run_prio,
    output logic               irq,
    output logic               fiq,
    output logic               wake
);
    logic [PRIO_W-1:0]              mask;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [NUM_SRC-1:0]             active;
    logic                           hit, full, take, to_irq;
    logic [IDX_W-1:0]               best_idx;
    logic [PRIO_W-1:0]              best_prio;

    prio_regs #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .PRIO_BITS(PRIO_BITS)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_secure(wr_secure),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .mask_o(mask), .prio_o(prio)
    );

    prio_select #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_sel (
        .pend(src_pend), .active(active), .prio(prio), .mask(mask),
        .run_prio(run_prio), .stall(full), .hit(hit), .best_idx(best_idx),
        .best_prio(best_prio), .wake(wake)
    );

    prio_run_stack #(.DEPTH(STACK_DEPTH)) i_stack (
        .clk(clk), .rst_n(rst_n), .push(take), .push_prio(best_prio),
        .pop(eoi), .run_prio(run_prio), .full(full)
    );

    // An acknowledge only takes effect with a winner and no competing end-of-interrupt
    assign take = ack && hit && !eoi;

    // Route the winner: own-state group 1 to IRQ, everything else to FIQ
    always_comb begin
        to_irq = src_grp[best_idx] && (src_sec[best_idx] == cur_secure);
        irq    = hit && to_irq;
        fiq    = hit && !to_irq;
        ack_id = hit ? (ID_W'(ID_BASE) + ID_W'(best_idx)) : SPURIOUS_ID;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_act
        // Active flag: set by the acknowledge that selects it, cleared by its end-of-interrupt
        always_ff @(posedge clk) begin
            if (!rst_n)                                        active[i] <= 1'b0;
            else if (eoi && eoi_id == ID_W'(ID_BASE + i))      active[i] <= 1'b0;
            else if (take && best_idx == IDX_W'(i))            active[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/prio_cpu_if_chk.sv
// Port-level protocol checks for prio_cpu_if, attached by bind.
// Assumes the ports of prio_cpu_if; observes only, drives nothing.
module prio_cpu_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack,
    input logic       eoi,
    input logic [9:0] ack_id,
    input logic [7:0] run_prio,
    input logic       irq,
    input logic       fiq,
    input logic       wake
);
    // R9
    irq_fiq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(irq && fiq));

    // R10
    signal_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n) (irq || fiq) |-> wake);

    // R7
    ack_raises_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eoi && (irq || fiq)) |=> (run_prio < $past(run_prio)));

    // R6
    spurious_ack_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eoi && !irq && !fiq) |=> $stable(run_prio));

    // R6
    spurious_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !fiq) |-> (ack_id == 10'd1023));

    // R5
    real_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || fiq) |-> (ack_id != 10'd1023));

    // R8
    idle_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && run_prio == 8'hFF) |=> (run_prio == 8'hFF));
endmodule

bind prio_cpu_if prio_cpu_if_chk i_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .ack_id(ack_id),
    .run_prio(run_prio), .irq(irq), .fiq(fiq), .wake(wake)
);

// File: tb/test_prio_cpu_if.sv
// Self-checking bench: table of selection vectors, then directed reset, write and nesting tests.
module test_prio_cpu_if;
    localparam int N = 4;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_pend = '0, src_grp = '0, src_sec = '0;
    logic          cur_secure = 1'b0;
    logic          wr_en = 1'b0, wr_secure = 1'b0;
    logic [SW-1:0] wr_sel = '0, rd_sel = '0;
    logic [7:0]    wr_data = '0, rd_data, run_prio;
    logic          ack = 1'b0, eoi = 1'b0;
    logic [9:0]    ack_id, eoi_id = '0;
    logic          irq, fiq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    prio_cpu_if #(.NUM_SRC(N), .STACK_DEPTH(2), .ID_BASE(32), .PRIO_BITS(8)) i_prio_cpu_if (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_grp(src_grp), .src_sec(src_sec),
        .cur_secure(cur_secure), .wr_en(wr_en), .wr_secure(wr_secure), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ack(ack), .ack_id(ack_id),
        .eoi(eoi), .eoi_id(eoi_id), .run_prio(run_prio), .irq(irq), .fiq(fiq), .wake(wake)
    );

    always #10 clk = ~clk;

    // Vector: {pend[3:0], mask[7:0], cur_secure, exp_id[9:0], exp_irq, exp_fiq, exp_wake}
    localparam int NV = 9;
    localparam logic [25:0] VEC [NV] = '{
        {4'b1111, 8'hFF, 1'b0, 10'd33,   1'b0, 1'b1, 1'b1},  // tie 0x20 -> src1, other-state group1 -> fiq
        {4'b1111, 8'hFF, 1'b1, 10'd33,   1'b1, 1'b0, 1'b1},  // same, own state -> irq
        {4'b1001, 8'hFF, 1'b0, 10'd32,   1'b0, 1'b1, 1'b1},  // 0x40 beats 0x90, group0 -> fiq
        {4'b1000, 8'hFF, 1'b0, 10'd35,   1'b1, 1'b0, 1'b1},  // ns group1 own state -> irq
        {4'b1000, 8'h90, 1'b0, 10'd1023, 1'b0, 1'b0, 1'b0},  // equal to mask blocks
        {4'b1000, 8'h91, 1'b0, 10'd35,   1'b1, 1'b0, 1'b1},  // one above mask passes
        {4'b0101, 8'h40, 1'b0, 10'd34,   1'b0, 1'b1, 1'b1},  // src0 at mask blocked, src2 wins
        {4'b0000, 8'hFF, 1'b0, 10'd1023, 1'b0, 1'b0, 1'b0},  // nothing pending
        {4'b0001, 8'h40, 1'b0, 10'd1023, 1'b0, 1'b0, 1'b0}   // only source masked
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic sec, input logic [SW-1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_secure = sec; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic do_eoi(input logic [9:0] id);
        eoi = 1'b1; eoi_id = id;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic rd(input logic [SW-1:0] sel, output logic [7:0] v);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 mask", v, 8'h00);
        rd(1, v); chk("R1 prio", v, 8'hFF);
        chk("R1 run_prio", run_prio, 8'hFF);
        chk("R1 outputs", {irq, fiq, wake}, 3'b000);
        chk("R1 ack_id", ack_id, 10'd1023);

        // R2 secure programming and readback
        wr(1'b1, 1, 8'h40);
        wr(1'b1, 2, 8'h20);
        wr(1'b1, 3, 8'h20);
        rd(1, v); chk("R2 prio src0", v, 8'h40);
        rd(2, v); chk("R2 prio src1", v, 8'h20);

        // R3 non-secure compression: 0x20 -> 0x90, mask 0x00 -> 0x80, 0xFF -> 0xFF
        wr(1'b0, 4, 8'h20);
        rd(4, v); chk("R3 prio src3", v, 8'h90);
        wr(1'b0, 0, 8'h00);
        rd(0, v); chk("R3 mask low", v, 8'h80);
        wr(1'b0, 0, 8'hFF);
        rd(0, v); chk("R3 mask high", v, 8'hFF);

        src_grp = 4'b1010;
        src_sec = 4'b0010;

        // R4 R5 R9 R10 selection table
        for (int k = 0; k < NV; k++) begin
            wr(1'b1, 0, VEC[k][21:14]);
            src_pend   = VEC[k][25:22];
            cur_secure = VEC[k][13];
            #1;
            chk("R5 ack_id", ack_id, VEC[k][12:3]);
            chk("R9 irq/fiq", {irq, fiq}, VEC[k][2:1]);
            chk("R10 wake", wake, VEC[k][0]);
            @(negedge clk);
        end

        // R7 nesting: src3 (0x90) then src0 (0x40)
        wr(1'b1, 0, 8'hFF);
        cur_secure = 1'b0;
        src_pend = 4'b1000;
        #1 chk("R7 first id", ack_id, 10'd35);
        @(negedge clk);
        do_ack();
        chk("R7 run after ack", run_prio, 8'h90);
        chk("R7 active not reselected", ack_id, 10'd1023);
        src_pend = 4'b1001;
        #1 chk("R4 below running", ack_id, 10'd32);
        @(negedge clk);
        do_ack();
        chk("R7 nested run", run_prio, 8'h40);

        // R11 stack full blocks src1 (0x20 < 0x40)
        src_pend = 4'b1111;
        #1 chk("R11 full blocks", ack_id, 10'd1023);
        chk("R10 wake while blocked", wake, 1'b1);
        @(negedge clk);
        do_ack();
        chk("R6 spurious ack", run_prio, 8'h40);

        // R8 pop order
        do_eoi(10'd32);
        chk("R8 pop to 0x90", run_prio, 8'h90);
        #1 chk("R5 after pop", ack_id, 10'd33);
        @(negedge clk);
        do_eoi(10'd40);
        chk("R8 pop to idle", run_prio, 8'hFF);
        src_pend = 4'b1000;
        #1 chk("R7 still active", ack_id, 10'd1023);
        @(negedge clk);
        do_eoi(10'd35);
        chk("R8 empty eoi", run_prio, 8'hFF);
        #1 chk("R7 reselect after eoi", ack_id, 10'd35);
        @(negedge clk);

        // R8 eoi wins over simultaneous ack
        ack = 1'b1; eoi = 1'b1; eoi_id = 10'd40;
        @(negedge clk);
        ack = 1'b0; eoi = 1'b0;
        chk("R8 eoi precedence", run_prio, 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule